// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a lower-level memory. It keeps 8 KB of data as 256 lines of 32 bytes. Every line has a single home chosen by the address, and each line carries a valid bit and a stored tag. Loads that find their line present are answered one cycle after acceptance. Loads that miss fetch the whole line over a line-wide read port, install it, and return the requested word.

Stores always go to memory. They enter a four-entry write buffer, which drains one word at a time over a word-wide write port. A store whose line is already cached also patches the cached copy. A store that misses leaves the cache alone. The processor is held back on a store only when the buffer is full. A load miss is held back until no buffered store to the same line remains, so the line it fetches is never stale. Load misses never produce memory writes of their own.

Top module: `dcache_wt`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is high, and `mem_rd_req_valid`, `mem_wr_valid` and `cpu_rsp_valid` are low. The first load to any address therefore misses.
- R2: The address is split from the low end into a 5-bit byte offset, an 8-bit line index and a 21-bit tag. A fetch is issued at the line address with the low 5 bits zero. Two addresses with the same index and different tags compete for one line.
- R3: A load that hits raises `cpu_rsp_valid` in the cycle after acceptance. It returns the word selected by address bits [4:2] and makes no memory read.
- R4: A load that misses makes exactly one line fetch. It returns the requested word after the fill, and later loads to that line hit.
- R5: Every accepted store appears once on the memory write port with its word address, data and byte enables, and stores appear in the order they were accepted.
- R6: A store that hits updates the cached word in exactly the bytes whose enable is set. A later hitting load returns the merged word.
- R7: A store that misses does not install the line. A later load to that line misses and fetches it.
- R8: The write buffer holds four stores. With four stores pending, a new store sees `cpu_req_ready` low until an entry drains.
- R9: A load miss issues its fetch only after every buffered store to the same line has drained. Load misses cause no memory writes.
- R10: A fill replaces whatever line occupied that index, so the previous tag misses afterwards.
- R11: While a load miss is being serviced, `cpu_req_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Request accepted this cycle when valid |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 34 | Word-aligned byte address |
| cpu_req_wdata | input | 32 | Store data |
| cpu_req_be | input | 4 | Store byte enables |
| cpu_rsp_valid | output | 1 | Load data valid, one cycle |
| cpu_rsp_rdata | output | 32 | Load data |
| mem_rd_req_valid | output | 1 | Line fetch request |
| mem_rd_req_ready | input | 1 | Memory accepts the fetch |
| mem_rd_addr | output | 34 | Line-aligned fetch address |
| mem_rd_rsp_valid | input | 1 | Fetched line present, one cycle |
| mem_rd_rsp_line | input | 256 | Fetched line, word 0 in the low bits |
| mem_wr_valid | output | 1 | Buffered store present |
| mem_wr_ready | input | 1 | Memory takes the store |
| mem_wr_addr | output | 34 | Store word address |
| mem_wr_data | output | 32 | Store data |
| mem_wr_be | output | 4 | Store byte enables |

## Verification
The bench builds the cache with its default parameters: 34-bit addresses, 32-byte lines, 256 lines and four buffer entries. With these values an address 8 KB away lands on the same index, which makes eviction easy to provoke. Four stores are enough to fill the buffer. A bench-controlled stall on the memory write port lets stores pile up, which brings the full-buffer stall and the drain-before-fetch ordering within reach. A reference memory model with a fixed fetch latency supplies lines and counts every read and write the cache makes.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    typedef enum logic [1:0] {
        CS_IDLE,
        CS_DRAIN,
        CS_FETCH,
        CS_FILL
    } cstate_e;
endpackage

// File: rtl/dcache_wbuf.sv
module dcache_wbuf #(
    parameter int ADDR_W = 34,
    parameter int WORD_W = 32,
    parameter int DEPTH  = 4,
    parameter int OFF_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic [ADDR_W-1:0]        push_addr_i,
    input  logic [WORD_W-1:0]        push_data_i,
    input  logic [WORD_W/8-1:0]      push_be_i,
    output logic                     full_o,
    output logic                     head_valid_o,
    output logic [ADDR_W-1:0]        head_addr_o,
    output logic [WORD_W-1:0]        head_data_o,
    output logic [WORD_W/8-1:0]      head_be_o,
    input  logic                     head_ack_i,
    input  logic [ADDR_W-OFF_W-1:0]  probe_line_i,
    output logic                     probe_hit_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int BE_W  = WORD_W / 8;

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [PTR_W-1:0]             wptr;
        logic [PTR_W-1:0]             rptr;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][WORD_W-1:0] data;
        logic [DEPTH-1:0][BE_W-1:0]   be;
    } wb_t;

    wb_t wb_d, wb_q;
    logic [DEPTH-1:0] slot_match;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        wb_d = wb_q;
        if (head_ack_i && wb_q.vld[wb_q.rptr]) begin
            wb_d.vld[wb_q.rptr] = 1'b0;
            wb_d.rptr           = bump(wb_q.rptr);
        end
        if (push_i && !wb_q.vld[wb_q.wptr]) begin
            wb_d.vld[wb_q.wptr]  = 1'b1;
            wb_d.addr[wb_q.wptr] = push_addr_i;
            wb_d.data[wb_q.wptr] = push_data_i;
            wb_d.be[wb_q.wptr]   = push_be_i;
            wb_d.wptr            = bump(wb_q.wptr);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_probe
            assign slot_match[i] = wb_q.vld[i] &&
                (wb_q.addr[i][ADDR_W-1:OFF_W] == probe_line_i);
        end
    endgenerate

    assign probe_hit_o  = |slot_match;
    assign full_o       = wb_q.vld[wb_q.wptr];
    assign head_valid_o = wb_q.vld[wb_q.rptr];
    assign head_addr_o  = wb_q.addr[wb_q.rptr];
    assign head_data_o  = wb_q.data[wb_q.rptr];
    assign head_be_o    = wb_q.be[wb_q.rptr];

    // R8: the controller never pushes into a full buffer
    assert_no_push_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    // R5: a stalled store holds its address, data and enables
    assert_head_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid_o && !head_ack_i) |=> (head_valid_o && $stable(head_addr_o)
                                           && $stable(head_data_o) && $stable(head_be_o)));
endmodule

// File: rtl/dcache_lines.sv
module dcache_lines #(
    parameter int NUM_LINES = 256,
    parameter int IDX_W     = 8,
    parameter int TAG_W     = 21,
    parameter int LINE_W    = 256,
    parameter int WORD_W    = 32,
    parameter int WSEL_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IDX_W-1:0]     look_idx_i,
    output logic                 look_valid_o,
    output logic [TAG_W-1:0]     look_tag_o,
    output logic [LINE_W-1:0]    look_line_o,
    input  logic                 fill_i,
    input  logic [IDX_W-1:0]     fill_idx_i,
    input  logic [TAG_W-1:0]     fill_tag_i,
    input  logic [LINE_W-1:0]    fill_line_i,
    input  logic                 upd_i,
    input  logic [IDX_W-1:0]     upd_idx_i,
    input  logic [WSEL_W-1:0]    upd_wsel_i,
    input  logic [WORD_W-1:0]    upd_data_i,
    input  logic [WORD_W/8-1:0]  upd_be_i
);
    localparam int BE_W = WORD_W / 8;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [TAG_W-1:0]  tag;
        logic [LINE_W-1:0] line;
    } wport_t;

    logic [NUM_LINES-1:0] vld_d, vld_q;
    logic [TAG_W-1:0]     tag_q  [NUM_LINES];
    logic [LINE_W-1:0]    data_q [NUM_LINES];
    wport_t               wport;

    always_comb begin
        vld_d = vld_q;
        wport = '0;
        if (fill_i) begin
            wport.en          = 1'b1;
            wport.idx         = fill_idx_i;
            wport.tag         = fill_tag_i;
            wport.line        = fill_line_i;
            vld_d[fill_idx_i] = 1'b1;
        end else if (upd_i) begin
            wport.en   = 1'b1;
            wport.idx  = upd_idx_i;
            wport.tag  = tag_q[upd_idx_i];
            wport.line = data_q[upd_idx_i];
            for (int b = 0; b < BE_W; b++) begin
                if (upd_be_i[b])
                    wport.line[int'(upd_wsel_i)*WORD_W + b*8 +: 8] = upd_data_i[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        if (wport.en) begin
            tag_q[wport.idx]  <= wport.tag;
            data_q[wport.idx] <= wport.line;
        end
    end

    assign look_valid_o = vld_q[look_idx_i];
    assign look_tag_o   = tag_q[look_idx_i];
    assign look_line_o  = data_q[look_idx_i];

    // R4: a fill leaves its line valid
    assert_fill_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i |=> vld_q[$past(fill_idx_i)]);

    // R6: fills and store patches never share a cycle
    assert_single_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_i && upd_i));
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
    parameter int ADDR_W     = 34,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 256,
    parameter int WORD_BYTES = 4,
    parameter int WB_DEPTH   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req_valid,
    output logic                      cpu_req_ready,
    input  logic                      cpu_req_we,
    input  logic [ADDR_W-1:0]         cpu_req_addr,
    input  logic [8*WORD_BYTES-1:0]   cpu_req_wdata,
    input  logic [WORD_BYTES-1:0]     cpu_req_be,
    output logic                      cpu_rsp_valid,
    output logic [8*WORD_BYTES-1:0]   cpu_rsp_rdata,
    output logic                      mem_rd_req_valid,
    input  logic                      mem_rd_req_ready,
    output logic [ADDR_W-1:0]         mem_rd_addr,
    input  logic                      mem_rd_rsp_valid,
    input  logic [8*LINE_BYTES-1:0]   mem_rd_rsp_line,
    output logic                      mem_wr_valid,
    input  logic                      mem_wr_ready,
    output logic [ADDR_W-1:0]         mem_wr_addr,
    output logic [8*WORD_BYTES-1:0]   mem_wr_data,
    output logic [WORD_BYTES-1:0]     mem_wr_be
);
    import dcache_pkg::*;

    localparam int WORD_W  = 8 * WORD_BYTES;
    localparam int LINE_W  = 8 * LINE_BYTES;
    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int BOFF_W  = $clog2(WORD_BYTES);
    localparam int WSEL_W  = OFF_W - BOFF_W;
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int WADDR_W = ADDR_W - BOFF_W;

    typedef struct packed {
        cstate_e            st;
        logic [WADDR_W-1:0] maddr;
        logic               rsp_v;
        logic [WORD_W-1:0]  rsp_d;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0]   req_idx;
    logic [TAG_W-1:0]   req_tag;
    logic [WSEL_W-1:0]  req_wsel;
    logic [LADDR_W-1:0] miss_line;
    logic [IDX_W-1:0]   miss_idx;
    logic [TAG_W-1:0]   miss_tag;
    logic [WSEL_W-1:0]  miss_wsel;
    logic               look_valid;
    logic [TAG_W-1:0]   look_tag;
    logic [LINE_W-1:0]  look_line;
    logic               hit;
    logic               accept;
    logic               store_push;
    logic               fill;
    logic               wb_full;
    logic               wb_line_hit;

    function automatic logic [WORD_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                                input logic [WSEL_W-1:0] s);
        return ln[int'(s)*WORD_W +: WORD_W];
    endfunction

    assign req_idx   = cpu_req_addr[OFF_W +: IDX_W];
    assign req_tag   = cpu_req_addr[ADDR_W-1 -: TAG_W];
    assign req_wsel  = cpu_req_addr[BOFF_W +: WSEL_W];
    assign miss_line = ctl_q.maddr[WADDR_W-1:WSEL_W];
    assign miss_idx  = miss_line[IDX_W-1:0];
    assign miss_tag  = miss_line[LADDR_W-1:IDX_W];
    assign miss_wsel = ctl_q.maddr[WSEL_W-1:0];

    assign hit           = look_valid && (look_tag == req_tag);
    assign cpu_req_ready = (ctl_q.st == CS_IDLE) && (!cpu_req_we || !wb_full);
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign store_push    = accept && cpu_req_we;
    assign fill          = (ctl_q.st == CS_FILL) && mem_rd_rsp_valid;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        unique case (ctl_q.st)
            CS_IDLE: begin
                if (accept && !cpu_req_we) begin
                    if (hit) begin
                        ctl_d.rsp_v = 1'b1;
                        ctl_d.rsp_d = pick(look_line, req_wsel);
                    end else begin
                        ctl_d.st    = CS_DRAIN;
                        ctl_d.maddr = cpu_req_addr[ADDR_W-1:BOFF_W];
                    end
                end
            end
            CS_DRAIN: begin
                if (!wb_line_hit) ctl_d.st = CS_FETCH;
            end
            CS_FETCH: begin
                if (mem_rd_req_ready) ctl_d.st = CS_FILL;
            end
            CS_FILL: begin
                if (mem_rd_rsp_valid) begin
                    ctl_d.st    = CS_IDLE;
                    ctl_d.rsp_v = 1'b1;
                    ctl_d.rsp_d = pick(mem_rd_rsp_line, miss_wsel);
                end
            end
            default: ctl_d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{st: CS_IDLE, default: '0};
        else        ctl_q <= ctl_d;
    end

    assign cpu_rsp_valid    = ctl_q.rsp_v;
    assign cpu_rsp_rdata    = ctl_q.rsp_d;
    assign mem_rd_req_valid = (ctl_q.st == CS_FETCH);
    assign mem_rd_addr      = {miss_line, {OFF_W{1'b0}}};

    dcache_lines #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W),
        .LINE_W    (LINE_W),
        .WORD_W    (WORD_W),
        .WSEL_W    (WSEL_W)
    ) u_lines (
        .clk          (clk),
        .rst_n        (rst_n),
        .look_idx_i   (req_idx),
        .look_valid_o (look_valid),
        .look_tag_o   (look_tag),
        .look_line_o  (look_line),
        .fill_i       (fill),
        .fill_idx_i   (miss_idx),
        .fill_tag_i   (miss_tag),
        .fill_line_i  (mem_rd_rsp_line),
        .upd_i        (store_push && hit),
        .upd_idx_i    (req_idx),
        .upd_wsel_i   (req_wsel),
        .upd_data_i   (cpu_req_wdata),
        .upd_be_i     (cpu_req_be)
    );

    dcache_wbuf #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .DEPTH  (WB_DEPTH),
        .OFF_W  (OFF_W)
    ) u_wbuf (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (store_push),
        .push_addr_i  (cpu_req_addr),
        .push_data_i  (cpu_req_wdata),
        .push_be_i    (cpu_req_be),
        .full_o       (wb_full),
        .head_valid_o (mem_wr_valid),
        .head_addr_o  (mem_wr_addr),
        .head_data_o  (mem_wr_data),
        .head_be_o    (mem_wr_be),
        .head_ack_i   (mem_wr_ready),
        .probe_line_i (miss_line),
        .probe_hit_o  (wb_line_hit)
    );

    // R9: no fetch while a store to the same line is still buffered
    assert_fetch_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req_valid |-> !wb_line_hit);

    // R4: a pending fetch holds its address until taken
    assert_fetch_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req_valid && !mem_rd_req_ready) |=> (mem_rd_req_valid && $stable(mem_rd_addr)));

    // R11: a line arriving finishes the miss with a response
    assert_fill_responds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> (cpu_rsp_valid && cpu_req_ready == !(cpu_req_we && wb_full)));
endmodule

// File: tb/test_dcache_wt.sv
module test_dcache_wt;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req_valid = 1'b0;
    logic         cpu_req_ready;
    logic         cpu_req_we = 1'b0;
    logic [33:0]  cpu_req_addr = '0;
    logic [31:0]  cpu_req_wdata = '0;
    logic [3:0]   cpu_req_be = '0;
    logic         cpu_rsp_valid;
    logic [31:0]  cpu_rsp_rdata;
    logic         mem_rd_req_valid;
    logic         mem_rd_req_ready;
    logic [33:0]  mem_rd_addr;
    logic         mem_rd_rsp_valid = 1'b0;
    logic [255:0] mem_rd_rsp_line = '0;
    logic         mem_wr_valid;
    logic         mem_wr_ready;
    logic [33:0]  mem_wr_addr;
    logic [31:0]  mem_wr_data;
    logic [3:0]   mem_wr_be;

    int checks = 0;
    int failures = 0;
    int stores_issued = 0;
    int rd_count = 0;
    int wr_count = 0;
    logic [33:0] last_fetch = '0;
    logic wr_stall = 1'b0;

    logic [31:0] mem_m [logic [31:0]];
    logic [31:0] ref_m [logic [31:0]];

    localparam int FETCH_LAT = 3;
    logic       pend = 1'b0;
    int         pend_cnt = 0;
    logic [33:0] pend_addr = '0;

    always #10 clk = ~clk;

    assign mem_rd_req_ready = 1'b1;
    assign mem_wr_ready     = !wr_stall;

    dcache_wt i_dcache_wt (
        .clk              (clk),
        .rst_n            (rst_n),
        .cpu_req_valid    (cpu_req_valid),
        .cpu_req_ready    (cpu_req_ready),
        .cpu_req_we       (cpu_req_we),
        .cpu_req_addr     (cpu_req_addr),
        .cpu_req_wdata    (cpu_req_wdata),
        .cpu_req_be       (cpu_req_be),
        .cpu_rsp_valid    (cpu_rsp_valid),
        .cpu_rsp_rdata    (cpu_rsp_rdata),
        .mem_rd_req_valid (mem_rd_req_valid),
        .mem_rd_req_ready (mem_rd_req_ready),
        .mem_rd_addr      (mem_rd_addr),
        .mem_rd_rsp_valid (mem_rd_rsp_valid),
        .mem_rd_rsp_line  (mem_rd_rsp_line),
        .mem_wr_valid     (mem_wr_valid),
        .mem_wr_ready     (mem_wr_ready),
        .mem_wr_addr      (mem_wr_addr),
        .mem_wr_data      (mem_wr_data),
        .mem_wr_be        (mem_wr_be)
    );

    function automatic logic [31:0] seed_word(input logic [31:0] k);
        return k ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] k);
        return mem_m.exists(k) ? mem_m[k] : seed_word(k);
    endfunction

    function automatic logic [31:0] ref_word(input logic [31:0] k);
        return ref_m.exists(k) ? ref_m[k] : seed_word(k);
    endfunction

    // lower-level memory model
    always @(posedge clk) begin
        if (!rst_n) begin
            pend             <= 1'b0;
            mem_rd_rsp_valid <= 1'b0;
        end else begin
            mem_rd_rsp_valid <= 1'b0;
            if (mem_rd_req_valid && mem_rd_req_ready) begin
                pend       <= 1'b1;
                pend_cnt   <= FETCH_LAT;
                pend_addr  <= mem_rd_addr;
                last_fetch <= mem_rd_addr;
                rd_count   <= rd_count + 1;
            end else if (pend) begin
                if (pend_cnt == 0) begin
                    logic [255:0] ln;
                    for (int w = 0; w < 8; w++)
                        ln[w*32 +: 32] = mem_word({pend_addr[33:5], 3'(w)});
                    mem_rd_rsp_line  <= ln;
                    mem_rd_rsp_valid <= 1'b1;
                    pend             <= 1'b0;
                end else begin
                    pend_cnt <= pend_cnt - 1;
                end
            end
            if (mem_wr_valid && mem_wr_ready) begin
                logic [31:0] k;
                logic [31:0] v;
                k = mem_wr_addr[33:2];
                v = mem_word(k);
                for (int b = 0; b < 4; b++)
                    if (mem_wr_be[b]) v[b*8 +: 8] = mem_wr_data[b*8 +: 8];
                mem_m[k] = v;
                wr_count <= wr_count + 1;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cpu_read(input logic [33:0] a, output logic [31:0] d, output int lat);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = 1'b0;
        cpu_req_addr  = a;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 0;
        while (!cpu_rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        d = cpu_rsp_rdata;
    endtask

    task automatic cpu_write(input logic [33:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] v;
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = 1'b1;
        cpu_req_addr  = a;
        cpu_req_wdata = d;
        cpu_req_be    = be;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        cpu_req_we    = 1'b0;
        stores_issued++;
        v = ref_word(a[33:2]);
        for (int b = 0; b < 4; b++) if (be[b]) v[b*8 +: 8] = d[b*8 +: 8];
        ref_m[a[33:2]] = v;
    endtask

    task automatic wait_drain();
        while (wr_count != stores_issued) @(negedge clk);
        @(negedge clk);
    endtask

    localparam logic [33:0] A0 = 34'h0_0000_0100;

    task automatic t_reset();
        @(negedge clk);
        chk("R1", "ready after reset", cpu_req_ready, 1);
        chk("R1", "no fetch after reset", mem_rd_req_valid, 0);
        chk("R1", "no store after reset", mem_wr_valid, 0);
        chk("R1", "no response after reset", cpu_rsp_valid, 0);
    endtask

    task automatic t_miss_then_hit();
        logic [31:0] d;
        int lat;
        int r0;
        r0 = rd_count;
        cpu_read(A0 + 34'h8, d, lat);
        chk("R1", "first read fetches", rd_count - r0, 1);
        chk("R2", "fetch line aligned", last_fetch, A0);
        chk("R4", "miss data", d, ref_word(A0[33:2] + 2));
        cpu_read(A0 + 34'h14, d, lat);
        chk("R3", "hit no fetch", rd_count - r0, 1);
        chk("R3", "hit latency", lat, 0);
        chk("R3", "hit word 5", d, ref_word(A0[33:2] + 5));
    endtask

    task automatic t_write_hit();
        logic [31:0] d;
        int lat;
        int r0;
        r0 = rd_count;
        cpu_write(A0 + 34'h8, 32'h1122_3344, 4'b0101);
        wait_drain();
        cpu_read(A0 + 34'h8, d, lat);
        chk("R6", "merged word", d, ref_word(A0[33:2] + 2));
        chk("R6", "hit after store no fetch", rd_count - r0, 0);
        chk("R5", "memory got store", mem_word(A0[33:2] + 2), ref_word(A0[33:2] + 2));
    endtask

    task automatic t_write_miss();
        logic [31:0] d;
        int lat;
        int r0;
        logic [33:0] b;
        b  = 34'h3_0000_0240;
        r0 = rd_count;
        cpu_write(b, 32'hCAFE_F00D, 4'b1111);
        wait_drain();
        chk("R7", "store miss no fetch", rd_count - r0, 0);
        chk("R5", "memory got miss store", mem_word(b[33:2]), 32'hCAFE_F00D);
        cpu_read(b, d, lat);
        chk("R7", "read after store miss fetches", rd_count - r0, 1);
        chk("R7", "read after store miss data", d, 32'hCAFE_F00D);
    endtask

    task automatic t_conflict();
        logic [31:0] d;
        int lat;
        int r0;
        int w0;
        logic [33:0] c;
        c  = A0 + 34'h2000;
        r0 = rd_count;
        w0 = wr_count;
        cpu_read(c + 34'h4, d, lat);
        chk("R2", "same index other tag misses", rd_count - r0, 1);
        chk("R10", "conflict data", d, ref_word(c[33:2] + 1));
        cpu_read(A0 + 34'h8, d, lat);
        chk("R10", "evicted line misses", rd_count - r0, 2);
        chk("R10", "refetched data", d, ref_word(A0[33:2] + 2));
        chk("R9", "read misses write nothing", wr_count - w0, 0);
    endtask

    task automatic t_buffer_full();
        int w0;
        w0 = wr_count;
        wr_stall = 1'b1;
        cpu_write(34'h1_0000_1000, 32'h0000_0001, 4'b1111);
        cpu_write(34'h1_0000_1000, 32'h0000_0002, 4'b1111);
        cpu_write(A0 + 34'h10, 32'hAABB_CCDD, 4'b1111);
        cpu_write(34'h1_0000_2004, 32'h0000_0004, 4'b0011);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = 1'b1;
        cpu_req_addr  = 34'h1_0000_1000;
        cpu_req_wdata = 32'h0000_0005;
        cpu_req_be    = 4'b1111;
        #1;
        chk("R8", "ready low when four pending", cpu_req_ready, 0);
        chk("R8", "nothing drained while stalled", wr_count - w0, 0);
        wr_stall = 1'b0;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        cpu_req_we    = 1'b0;
        stores_issued++;
        ref_m[32'h4000_0400] = 32'h0000_0005;
        wait_drain();
        chk("R5", "all stores reached memory", wr_count - w0, 5);
        chk("R5", "last store wins", mem_word(32'h4000_0400), 32'h0000_0005);
        chk("R5", "partial store", mem_word(32'h4000_0801), ref_word(32'h4000_0801));
    endtask

    task automatic t_drain_before_fetch();
        logic [33:0] a;
        int r0;
        int lat;
        logic [31:0] d;
        a  = 34'h2_0000_0300;
        r0 = rd_count;
        wr_stall = 1'b1;
        cpu_write(a + 34'hC, 32'h7777_8888, 4'b1111);
        @(negedge clk);
        cpu_req_valid = 1'b1;
        cpu_req_we    = 1'b0;
        cpu_req_addr  = a + 34'hC;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        for (int i = 0; i < 12; i++) @(negedge clk);
        chk("R9", "fetch held behind store", rd_count - r0, 0);
        chk("R11", "ready low during miss", cpu_req_ready, 0);
        wr_stall = 1'b0;
        lat = 0;
        while (!cpu_rsp_valid && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        d = cpu_rsp_rdata;
        chk("R9", "fetched data not stale", d, 32'h7777_8888);
        chk("R4", "one fetch for the miss", rd_count - r0, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_miss_then_hit();
        t_write_hit();
        t_write_miss();
        t_conflict();
        t_buffer_full();
        t_drain_before_fetch();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule